// File: doc/BRIEF.md
# Reset Source Funnel Controller

This block gathers every reset request of a small controller into one system reset. Power-on, a supply-voltage monitor, the external reset pin, a missing-clock detector and a comparator trip are asynchronous to the system clock. The watchdog expiry, a software reset write and a flash-fault event are synchronous to it. The supply monitor and the comparator each have their own enable. Any enabled asynchronous request raises the system reset at once, with no clock needed. Reset release is always synchronous. It comes a fixed number of clock edges after the last request seen through the synchronizers.

The block keeps a cause register with one flag per source. A reset that starts from the idle state overwrites the register with the set of sources that started it. Sources that arrive before the reset ends are added. Power-on is an exception: it leaves only its own flag. The block asks for the external reset pin to be pulled low only when the reset was caused by power-on or by the supply monitor. While reset is active, the block holds interrupt and timer enables off. It also supplies the constant start-up values that downstream state loads: port latches, program-counter start, watchdog enable and prescale, and clock source.

Top module: `rst_funnel_ctrl`

## Requirements
- R1: With `supmon_trip` (when `supmon_en`=1), `pin_rst`, `misclk_trip` or `cmp_trip` (when `cmp_en`=1) high, `sys_rst` is 1 before any clock edge. With `wdt_expire`, `sw_rst_wr` or `flash_fault` high, `sys_rst` is 1 after the first rising edge that samples it.
- R2: When `supmon_en`=0, a supply-monitor trip has no effect. When `cmp_en`=0, a comparator trip has no effect. In both cases `sys_rst` stays 0 and `rst_cause` keeps its value.
- R3: `sys_rst` falls at exactly the `STRETCH_CYCLES`-th rising edge after the last edge at which a request was sampled high. Asynchronous sources and power-on reach that sampling through `SYNC_STAGES` flops. With the defaults, an asynchronous request released between edges drops `sys_rst` after edge 18 counted from the release. A synchronous request held for H edges drops it after edge H+16.
- R4: A one-cycle `sw_rst_wr` pulse produces a complete reset with the same stretch as any other source.
- R5: The bits of `rst_cause` are: 0 power-on, 1 supply monitor, 2 pin, 3 missing clock, 4 watchdog, 5 comparator, 6 software, 7 flash fault. A reset entered from idle replaces the register with exactly the set of enabled active sources. Sources that appear before `sys_rst` falls are ORed in.
- R6: `pin_pull_low` is 1 only while `sys_rst` is 1 and the current cause includes bit 0 or bit 1. It is never 1 for the other sources.
- R7: `por_req` sets `sys_rst` and sets `rst_cause` to 8'h01 at once, without a clock. Other sources active during power-on add no flag.
- R8: `irq_en_allow` and `tmr_en_allow` are 0 while `sys_rst` is 1 and 1 otherwise.
- R9: `port_init` is all ones and `pc_init` is zero. `wdt_en_init` is 1. `wdt_div_sel` is 2'b00, which selects system clock divided by 12. `clk_src_sel` is 0, which selects the internal oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on request, active high, asynchronous |
| supmon_trip | input | 1 | Supply monitor trip, asynchronous |
| supmon_en | input | 1 | Enable for the supply-monitor source |
| pin_rst | input | 1 | External reset pin sensed low, active high, asynchronous |
| misclk_trip | input | 1 | Missing-clock one-shot, asynchronous |
| wdt_expire | input | 1 | Watchdog timeout, synchronous |
| cmp_trip | input | 1 | Comparator trip, asynchronous |
| cmp_en | input | 1 | Enable for the comparator source |
| sw_rst_wr | input | 1 | Software reset write strobe, synchronous |
| flash_fault | input | 1 | Flash error event, synchronous |
| sys_rst | output | 1 | Internal system reset, active high |
| pin_pull_low | output | 1 | Open-drain pull request for the external pin |
| rst_cause | output | 8 | Cause flags, bit map as in R5 |
| port_init | output | PORT_COUNT*8 | Port latch reset value |
| pc_init | output | PC_WIDTH | Program-counter start address |
| wdt_en_init | output | 1 | Watchdog enable after reset |
| wdt_div_sel | output | 2 | Watchdog prescale code, 2'b00 = divide by 12 |
| irq_en_allow | output | 1 | Interrupt enables permitted |
| tmr_en_allow | output | 1 | Timer enables permitted |
| clk_src_sel | output | 1 | Clock source, 0 = internal oscillator |

## Verification
An asynchronous assertion is checked one time step after the input is driven at a falling edge, before any clock edge. Synchronous sources are checked after the first rising edge. Every source is driven at a falling edge, and edges are counted from that point. The bench computes the release edge as H+STRETCH for synchronous sources and H+SYNC_STAGES+STRETCH when any enabled asynchronous source is present. It samples `sys_rst`, the cause flags and the pin request one edge before that release edge, and samples again just after it. Cause flags from asynchronous sources settle SYNC_STAGES+1 edges after assertion, so they are compared only at the late sample point.

// File: rtl/rst_funnel_pkg.sv
package rst_funnel_pkg;

   localparam int unsigned SRC_N = 8;

   // flag positions in the cause register
   localparam int unsigned SRC_POR    = 0;
   localparam int unsigned SRC_SUPMON = 1;
   localparam int unsigned SRC_PIN    = 2;
   localparam int unsigned SRC_MISCLK = 3;
   localparam int unsigned SRC_WDT    = 4;
   localparam int unsigned SRC_CMP    = 5;
   localparam int unsigned SRC_SW     = 6;
   localparam int unsigned SRC_FLASH  = 7;

   typedef logic [SRC_N-1:0] src_vec_t;

   localparam src_vec_t POR_ONLY    = src_vec_t'(1) << SRC_POR;
   localparam src_vec_t PIN_DRIVERS = (src_vec_t'(1) << SRC_POR) | (src_vec_t'(1) << SRC_SUPMON);

endpackage

// File: rtl/rst_sync_bank.sv
module rst_sync_bank #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             arst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rst_sync_bank: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("rst_sync_bank: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or posedge arst) begin
         if (arst) chain_q <= {STAGES{RST_VAL}};
         else      chain_q <= {chain_q[STAGES-2:0], d[i]};
      end
      assign q[i] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
   parameter int unsigned HOLD = 16
) (
   input  logic clk,
   input  logic por,
   input  logic hard_hit,
   input  logic any_req,
   output logic rst_o
);

   localparam int unsigned CW = $clog2(HOLD + 1);

   if (HOLD < 2) begin : g_bad_hold
      $error("rst_stretch: HOLD must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          rst_q;

   // asynchronous set, synchronous countdown release
   always_ff @(posedge clk or posedge hard_hit) begin
      if (hard_hit) begin
         cnt_q <= CW'(HOLD);
         rst_q <= 1'b1;
      end else if (any_req) begin
         cnt_q <= CW'(HOLD);
         rst_q <= 1'b1;
      end else begin
         if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         rst_q <= (cnt_q > CW'(1));
      end
   end

   assign rst_o = rst_q;

   // quiet-edge counter used only by the stretch check
   logic [CW-1:0] quiet_q;
   always_ff @(posedge clk or posedge por) begin
      if (por)                        quiet_q <= '0;
      else if (any_req)               quiet_q <= '0;
      else if (quiet_q != CW'(HOLD))  quiet_q <= quiet_q + 1'b1;
   end

   p_async_set_r1: assert property (@(posedge clk) disable iff (por)
      hard_hit |-> rst_q);

   p_stretch_min_r3: assert property (@(posedge clk) disable iff (por)
      $fell(rst_q) |-> (quiet_q >= CW'(HOLD)));

endmodule

// File: rtl/rst_cause_log.sv
module rst_cause_log
   import rst_funnel_pkg::*;
(
   input  logic     clk,
   input  logic     por,
   input  src_vec_t req,
   input  logic     rst_i,
   output src_vec_t cause_o,
   output logic     pin_o
);

   src_vec_t cause_q;
   logic     armed_q;   // 1: next request starts a fresh record

   always_ff @(posedge clk or posedge por) begin
      if (por) begin
         cause_q <= POR_ONLY;
         armed_q <= 1'b0;
      end else begin
         if (req[SRC_POR])   cause_q <= POR_ONLY;
         else if (|req)      cause_q <= armed_q ? req : (cause_q | req);

         if (|req)           armed_q <= 1'b0;
         else if (!rst_i)    armed_q <= 1'b1;
      end
   end

   assign cause_o = cause_q;
   assign pin_o   = rst_i & ~armed_q & (|(cause_q & PIN_DRIVERS));

   p_cause_filled_r5: assert property (@(posedge clk) disable iff (por)
      (|req) |=> (cause_q != '0));

   p_por_alone_r7: assert property (@(posedge clk) disable iff (por)
      req[SRC_POR] |=> ($countones(cause_q) == 1 && cause_q[SRC_POR]));

endmodule

// File: rtl/rst_funnel_ctrl.sv
module rst_funnel_ctrl
   import rst_funnel_pkg::*;
#(
   parameter int unsigned STRETCH_CYCLES  = 16,
   parameter int unsigned SYNC_STAGES     = 2,
   parameter bit          ASYNC_ASSERT    = 1'b1,
   parameter int unsigned PORT_COUNT      = 4,
   parameter int unsigned PC_WIDTH        = 16,
   parameter logic [1:0]  WDT_DIV_CODE    = 2'b00,
   parameter bit          CLK_SRC_DEFAULT = 1'b0
) (
   input  logic                    clk,
   input  logic                    por_req,
   input  logic                    supmon_trip,
   input  logic                    supmon_en,
   input  logic                    pin_rst,
   input  logic                    misclk_trip,
   input  logic                    wdt_expire,
   input  logic                    cmp_trip,
   input  logic                    cmp_en,
   input  logic                    sw_rst_wr,
   input  logic                    flash_fault,
   output logic                    sys_rst,
   output logic                    pin_pull_low,
   output logic [SRC_N-1:0]        rst_cause,
   output logic [PORT_COUNT*8-1:0] port_init,
   output logic [PC_WIDTH-1:0]     pc_init,
   output logic                    wdt_en_init,
   output logic [1:0]              wdt_div_sel,
   output logic                    irq_en_allow,
   output logic                    tmr_en_allow,
   output logic                    clk_src_sel
);

   localparam int unsigned PORT_BITS = PORT_COUNT * 8;
   localparam int unsigned ASYNC_N   = 4;

   if (STRETCH_CYCLES < 2) begin : g_bad_stretch
      $error("rst_funnel_ctrl: STRETCH_CYCLES must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rst_funnel_ctrl: SYNC_STAGES must be at least 2");
   end
   if (PORT_COUNT < 1) begin : g_bad_ports
      $error("rst_funnel_ctrl: PORT_COUNT must be at least 1");
   end
   if (PC_WIDTH < 8) begin : g_bad_pc
      $error("rst_funnel_ctrl: PC_WIDTH must be at least 8");
   end

   // synchronizers for asynchronous sources
   logic [ASYNC_N-1:0] a_raw;
   logic [ASYNC_N-1:0] a_sync;
   logic               por_sync;

   assign a_raw = {cmp_trip, misclk_trip, pin_rst, supmon_trip};

   rst_sync_bank #(.WIDTH(ASYNC_N), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_async_sync (
      .clk  (clk),
      .arst (por_req),
      .d    (a_raw),
      .q    (a_sync)
   );

   rst_sync_bank #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_por_sync (
      .clk  (clk),
      .arst (por_req),
      .d    (1'b0),
      .q    (por_sync)
   );

   // request vector in clock domain
   src_vec_t req;
   always_comb begin
      req             = '0;
      req[SRC_POR]    = por_sync;
      req[SRC_SUPMON] = a_sync[0] & supmon_en;
      req[SRC_PIN]    = a_sync[1];
      req[SRC_MISCLK] = a_sync[2];
      req[SRC_WDT]    = wdt_expire;
      req[SRC_CMP]    = a_sync[3] & cmp_en;
      req[SRC_SW]     = sw_rst_wr;
      req[SRC_FLASH]  = flash_fault;
   end

   // asynchronous assertion path
   logic hard_hit;
   if (ASYNC_ASSERT) begin : g_async_set
      assign hard_hit = por_req | (supmon_trip & supmon_en) | pin_rst
                      | misclk_trip | (cmp_trip & cmp_en);
   end else begin : g_sync_set
      assign hard_hit = por_req;
   end

   logic rst_int;

   rst_stretch #(.HOLD(STRETCH_CYCLES)) u_stretch (
      .clk      (clk),
      .por      (por_req),
      .hard_hit (hard_hit),
      .any_req  (|req),
      .rst_o    (rst_int)
   );

   src_vec_t cause_w;
   logic     pin_w;

   rst_cause_log u_cause (
      .clk     (clk),
      .por     (por_req),
      .req     (req),
      .rst_i   (rst_int),
      .cause_o (cause_w),
      .pin_o   (pin_w)
   );

   assign sys_rst      = rst_int;
   assign pin_pull_low = pin_w;
   assign rst_cause    = cause_w;
   assign irq_en_allow = ~rst_int;
   assign tmr_en_allow = ~rst_int;

   // downstream start-up values
   assign port_init   = {PORT_BITS{1'b1}};
   assign pc_init     = '0;
   assign wdt_en_init = 1'b1;
   assign wdt_div_sel = WDT_DIV_CODE;
   assign clk_src_sel = CLK_SRC_DEFAULT;

   p_pin_cause_r6: assert property (@(posedge clk) disable iff (por_req)
      pin_pull_low |-> (sys_rst && (rst_cause[SRC_POR] || rst_cause[SRC_SUPMON])));

endmodule

// File: tb/sim_rst_funnel_ctrl.sv
module sim_rst_funnel_ctrl;

   localparam int S  = 16;
   localparam int ST = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic por_req = 0, supmon_trip = 0, supmon_en = 0, pin_rst = 0, misclk_trip = 0;
   logic wdt_expire = 0, cmp_trip = 0, cmp_en = 0, sw_rst_wr = 0, flash_fault = 0;
   logic        sys_rst, pin_pull_low, wdt_en_init, irq_en_allow, tmr_en_allow, clk_src_sel;
   logic [7:0]  rst_cause;
   logic [31:0] port_init;
   logic [15:0] pc_init;
   logic [1:0]  wdt_div_sel;

   rst_funnel_ctrl u0 (
      .clk(clk), .por_req(por_req), .supmon_trip(supmon_trip), .supmon_en(supmon_en),
      .pin_rst(pin_rst), .misclk_trip(misclk_trip), .wdt_expire(wdt_expire),
      .cmp_trip(cmp_trip), .cmp_en(cmp_en), .sw_rst_wr(sw_rst_wr), .flash_fault(flash_fault),
      .sys_rst(sys_rst), .pin_pull_low(pin_pull_low), .rst_cause(rst_cause),
      .port_init(port_init), .pc_init(pc_init), .wdt_en_init(wdt_en_init),
      .wdt_div_sel(wdt_div_sel), .irq_en_allow(irq_en_allow), .tmr_en_allow(tmr_en_allow),
      .clk_src_sel(clk_src_sel)
   );

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   logic [7:0] last_cause = 8'h00;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(input logic [7:0] m);
      supmon_trip = m[1];
      pin_rst     = m[2];
      misclk_trip = m[3];
      wdt_expire  = m[4];
      cmp_trip    = m[5];
      sw_rst_wr   = m[6];
      flash_fault = m[7];
   endtask

   function automatic logic [7:0] eff_of(input logic [7:0] m, input bit se, input bit ce);
      logic [7:0] r;
      r = m;
      if (!se) r[1] = 1'b0;
      if (!ce) r[5] = 1'b0;
      return r;
   endfunction

   function automatic int fall_edge(input logic [7:0] eff, input int h);
      return ((eff & 8'h2E) != 0) ? h + ST + S : h + S;
   endfunction

   // one reset episode from idle: drive mask m for h edges, then release
   task automatic run_case(input logic [7:0] m, input bit se, input bit ce, input int h);
      logic [7:0] eff;
      int f;
      int n;
      supmon_en = se;
      cmp_en    = ce;
      eff = eff_of(m, se, ce);
      f   = fall_edge(eff, h);
      drive(m);
      #1;
      if ((eff & 8'h2E) != 0) chk("R1", "async set before edge", sys_rst, 1);
      n = 0;
      for (int k = 0; k < h; k++) begin
         tick();
         n++;
         if (n == 1) begin
            if (eff != 0) chk("R1", "reset after first edge", sys_rst, 1);
            else          chk("R2", "disabled source no reset", sys_rst, 0);
         end
      end
      drive(8'h00);
      if (eff == 0) begin
         for (int k = 0; k < ST + 2; k++) tick();
         chk("R2", "disabled source no reset later", sys_rst, 0);
         chk("R2", "cause untouched", rst_cause, last_cause);
         return;
      end
      while (n < f - 1) begin
         tick();
         n++;
      end
      chk("R3", "held one edge before release", sys_rst, 1);
      chk("R5", "cause flags", rst_cause, eff);
      chk("R6", "pin request", pin_pull_low, eff[1]);
      chk("R8", "irq gated", irq_en_allow, 0);
      tick();
      chk("R3", "released on expected edge", sys_rst, 0);
      chk("R8", "irq allowed", irq_en_allow, 1);
      chk("R8", "timer allowed", tmr_en_allow, 1);
      chk("R6", "pin released", pin_pull_low, 0);
      last_cause = eff;
      tick();
      tick();
   endtask

   initial begin
      int n;
      void'($urandom(32'h5EED));

      // power-on
      #1 por_req = 1'b1;
      #1;
      chk("R7", "por sets reset", sys_rst, 1);
      chk("R7", "por cause", rst_cause, 8'h01);
      chk("R6", "por drives pin", pin_pull_low, 1);
      chk("R8", "irq gated in por", irq_en_allow, 0);
      chk("R8", "timer gated in por", tmr_en_allow, 0);
      chk("R9", "port default", port_init, 32'hFFFF_FFFF);
      chk("R9", "pc default", pc_init, 0);
      chk("R9", "wdt enable", wdt_en_init, 1);
      chk("R9", "wdt div12 code", wdt_div_sel, 2'b00);
      chk("R9", "internal osc", clk_src_sel, 0);
      @(negedge clk);
      tick();
      tick();
      por_req = 1'b0;
      n = 0;
      while (n < ST + S - 1) begin tick(); n++; end
      chk("R7", "por held to stretch end", sys_rst, 1);
      chk("R7", "por cause kept", rst_cause, 8'h01);
      tick();
      chk("R3", "por release edge", sys_rst, 0);
      chk("R9", "wdt enable after exit", wdt_en_init, 1);
      last_cause = 8'h01;
      tick();
      tick();

      // directed cases
      run_case(8'h04, 1'b1, 1'b1, 3);   // R6: pin source must not drive pin
      run_case(8'h40, 1'b0, 1'b0, 1);   // R4: one-cycle software write
      run_case(8'h02, 1'b0, 1'b1, 4);   // R2: supply monitor disabled
      run_case(8'h20, 1'b1, 1'b0, 2);   // R2: comparator disabled
      run_case(8'h02, 1'b1, 1'b0, 2);   // R6: supply monitor drives pin
      run_case(8'h14, 1'b0, 1'b0, 3);   // R5: two sources together

      // R5: accumulation within one reset
      drive(8'h40);
      tick();
      drive(8'h00);
      for (int k = 0; k < 5; k++) tick();
      drive(8'h80);
      tick();
      drive(8'h00);
      n = 7;
      while (n < 7 + S - 1) begin tick(); n++; end
      chk("R5", "accumulated cause", rst_cause, 8'hC0);
      chk("R4", "still in reset", sys_rst, 1);
      tick();
      chk("R3", "release after late source", sys_rst, 0);
      last_cause = 8'hC0;
      tick();
      tick();

      // R7: power-on overrides other flags
      run_case(8'h10, 1'b0, 1'b0, 2);
      supmon_en   = 1'b1;
      por_req     = 1'b1;
      supmon_trip = 1'b1;
      #1;
      chk("R7", "por replaces cause", rst_cause, 8'h01);
      chk("R6", "pin in por", pin_pull_low, 1);
      for (int k = 0; k < 4; k++) tick();
      chk("R7", "others ignored in por", rst_cause, 8'h01);
      por_req     = 1'b0;
      supmon_trip = 1'b0;
      n = 0;
      while (n < ST + S - 1) begin tick(); n++; end
      chk("R7", "por only after stretch", rst_cause, 8'h01);
      tick();
      chk("R3", "por with monitor release", sys_rst, 0);
      last_cause = 8'h01;
      tick();
      tick();

      // constrained random episodes
      for (int it = 0; it < 60; it++) begin
         logic [7:0] m;
         if ($urandom_range(0, 2) == 0) m = 8'h01 << $urandom_range(1, 7);
         else                           m = 8'($urandom_range(1, 127)) << 1;
         run_case(m, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(1, 6));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule